// File: doc/BRIEF.md
# Prioritized Vectored Interrupt Controller

This block gathers single-cycle interrupt event pulses from a fixed set of sources, eleven by default. Each source has a fixed rank: the lower the source index, the more urgent the source. An event is latched into a per-source posted bit. A posted bit whose mask bit is also set counts as pending. While the global enable input is high and at least one source is pending, the controller raises a request to the processor and presents a vector address. The vector is the index of the most urgent pending source scaled by a fixed step.

Software acts on the block through write strobes:
- load the whole mask,
- clear chosen posted bits,
- clear every posted bit at once,
- raise chosen posted bits without a hardware event.

When the processor takes the presented interrupt it pulses an acknowledge. The posted bit of the presented source then drops at the same edge. A combinational read port returns the mask, posted or pending vector.

Masking only hides a source: a masked source keeps posting and keeps what it has posted. Unmasking it therefore makes it pending straight away. When setting and clearing collide in one cycle, setting wins, so no event is lost.

Top module: `prioIrqCtrl`

## Requirements
- R1: A 1 on `srcEvt[i]` at a rising clock edge makes posted bit i equal to 1 after that edge, whatever the mask and global enable.
- R2: A posted bit falls only at an edge where it is cleared by software (`clrWrEn` with that bit of `clrWrData`, or `clrAll`) or by an acknowledge of that source.
- R3: The pending vector equals posted AND mask. `rdData` is selected by `rdSel`: 0 returns the mask, 1 the posted vector, 2 the pending vector, and 3 returns all zeros.
- R4: Clearing a mask bit leaves that source's posted bit unchanged, and a new event on a masked source still posts it. Setting the mask bit again makes the source pending in the cycle after the mask write.
- R5: `irqReq` is 1 exactly when `globalEn` is 1 and at least one source is pending.
- R6: While `irqReq` is 1, `irqVec` equals the lowest pending source index times VEC_STEP (4 by default, giving 0x0000 to 0x0028). While `irqReq` is 0, `irqVec` is 0.
- R7: `setWrEn` makes posted bit i equal to 1 for every i where `setWrData[i]` is 1.
- R8: `clrWrEn` clears the posted bits where `clrWrData` is 1. `clrAll` clears all posted bits.
- R9: `ack` while `irqReq` is 1 clears only the posted bit of the source whose vector is presented. `ack` while `irqReq` is 0 changes nothing.
- R10: In the same cycle, a software set or a hardware event on a bit overrides a software clear, a clear-all or an acknowledge of that bit.
- R11: `rstN` low at a rising edge clears the mask and all posted bits (synchronous, active low), even if events arrive in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Synchronous reset, active low |
| srcEvt | input | NUM_SRC | Interrupt event pulses, bit i from source i |
| globalEn | input | 1 | Global interrupt enable |
| maskWrEn | input | 1 | Load mask from maskWrData |
| maskWrData | input | NUM_SRC | New mask value |
| clrWrEn | input | 1 | Clear posted bits selected by clrWrData |
| clrWrData | input | NUM_SRC | Bits to clear |
| clrAll | input | 1 | Clear every posted bit |
| setWrEn | input | 1 | Set posted bits selected by setWrData |
| setWrData | input | NUM_SRC | Bits to set |
| ack | input | 1 | Processor takes the presented interrupt (one cycle) |
| rdSel | input | 2 | Read select: 0 mask, 1 posted, 2 pending, 3 zero |
| irqReq | output | 1 | Interrupt request to the processor |
| irqVec | output | VEC_W | Vector address of the most urgent pending source |
| rdData | output | NUM_SRC | Read data |

## Verification
The bench builds the block with its defaults: NUM_SRC of 11, VEC_STEP of 4 and VEC_W of 16. With only eleven sources, every one of the 2047 nonzero pending patterns can be posted through the set strobe. For each pattern the bench checks the vector against the lowest set bit times four, with the global enable both on and off. All 2048 mask values are also swept over a fully posted vector. Directed sequences then cover each collision case: an acknowledge walk that drains a pattern from the most urgent source upward, and the set-over-clear cases.

// File: rtl/prioIrqPkg.sv
package prioIrqPkg;

  // Read port selector codes
  typedef enum logic [1:0] {
    RD_MASK    = 2'd0,
    RD_POSTED  = 2'd1,
    RD_PENDING = 2'd2,
    RD_NONE    = 2'd3
  } rdSel_e;

  // Strobes from control to datapath
  typedef struct packed {
    logic maskLoad;
    logic swClear;
    logic clearAll;
    logic swSet;
    logic take;
  } irqStrobes_t;

endpackage

// File: rtl/prioIrqControl.sv
module prioIrqControl
  import prioIrqPkg::*;
#(
  parameter int NUM_SRC  = 11,
  parameter int VEC_STEP = 4,
  parameter int VEC_W    = 16
) (
  input  logic               maskWrEn,
  input  logic               clrWrEn,
  input  logic               clrAll,
  input  logic               setWrEn,
  input  logic               ack,
  input  logic               globalEn,
  input  logic [NUM_SRC-1:0] pendingVec,
  output irqStrobes_t        strobes,
  output logic [NUM_SRC-1:0] takeSel,
  output logic               irqReq,
  output logic [VEC_W-1:0]   irqVec
);

  localparam int IDX_W = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1;

  logic             anyPend;
  logic [IDX_W-1:0] winIdx;

  // Fixed priority: lowest index wins
  always_comb begin
    anyPend = 1'b0;
    winIdx  = '0;
    for (int i = 0; i < NUM_SRC; i++) begin
      if (!anyPend && pendingVec[i]) begin
        anyPend = 1'b1;
        winIdx  = IDX_W'(i);
      end
    end
  end

  assign irqReq  = globalEn && anyPend;
  assign irqVec  = irqReq ? (VEC_W'(winIdx) * VEC_W'(VEC_STEP)) : '0;
  assign takeSel = irqReq ? (NUM_SRC'(1) << winIdx) : '0;

  always_comb begin
    strobes.maskLoad = maskWrEn;
    strobes.swClear  = clrWrEn;
    strobes.clearAll = clrAll;
    strobes.swSet    = setWrEn;
    strobes.take     = ack && irqReq;
  end

endmodule

// File: rtl/prioIrqDatapath.sv
module prioIrqDatapath
  import prioIrqPkg::*;
#(
  parameter int NUM_SRC = 11
) (
  input  logic               clk,
  input  logic               rstN,
  input  irqStrobes_t        strobes,
  input  logic [NUM_SRC-1:0] srcEvt,
  input  logic [NUM_SRC-1:0] maskWrData,
  input  logic [NUM_SRC-1:0] clrWrData,
  input  logic [NUM_SRC-1:0] setWrData,
  input  logic [NUM_SRC-1:0] takeSel,
  input  logic [1:0]         rdSel,
  output logic [NUM_SRC-1:0] postedVec,
  output logic [NUM_SRC-1:0] maskVec,
  output logic [NUM_SRC-1:0] pendingVec,
  output logic [NUM_SRC-1:0] rdData
);

  logic [NUM_SRC-1:0] postedQ;
  logic [NUM_SRC-1:0] postedNext;
  logic [NUM_SRC-1:0] maskQ;
  logic [NUM_SRC-1:0] clrBits;
  logic [NUM_SRC-1:0] setBits;

  always_comb begin
    clrBits = '0;
    if (strobes.swClear)  clrBits = clrBits | clrWrData;
    if (strobes.clearAll) clrBits = '1;
    if (strobes.take)     clrBits = clrBits | takeSel;
    setBits = srcEvt | (strobes.swSet ? setWrData : '0);
    // Set and events win over every clear source
    postedNext = (postedQ & ~clrBits) | setBits;
  end

  for (genvar g = 0; g < NUM_SRC; g++) begin : gPosted
    always_ff @(posedge clk) begin
      if (!rstN) postedQ[g] <= 1'b0;
      else       postedQ[g] <= postedNext[g];
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN)                 maskQ <= '0;
    else if (strobes.maskLoad) maskQ <= maskWrData;
  end

  assign postedVec  = postedQ;
  assign maskVec    = maskQ;
  assign pendingVec = postedQ & maskQ;

  always_comb begin
    case (rdSel_e'(rdSel))
      RD_MASK:    rdData = maskQ;
      RD_POSTED:  rdData = postedQ;
      RD_PENDING: rdData = pendingVec;
      default:    rdData = '0;
    endcase
  end

endmodule

// File: rtl/prioIrqCtrl.sv
module prioIrqCtrl
  import prioIrqPkg::*;
#(
  parameter int NUM_SRC  = 11,
  parameter int VEC_STEP = 4,
  parameter int VEC_W    = 16
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [NUM_SRC-1:0] srcEvt,
  input  logic               globalEn,
  input  logic               maskWrEn,
  input  logic [NUM_SRC-1:0] maskWrData,
  input  logic               clrWrEn,
  input  logic [NUM_SRC-1:0] clrWrData,
  input  logic               clrAll,
  input  logic               setWrEn,
  input  logic [NUM_SRC-1:0] setWrData,
  input  logic               ack,
  input  logic [1:0]         rdSel,
  output logic               irqReq,
  output logic [VEC_W-1:0]   irqVec,
  output logic [NUM_SRC-1:0] rdData
);

  irqStrobes_t        strobes;
  logic [NUM_SRC-1:0] takeSel;
  logic [NUM_SRC-1:0] postedVec;
  logic [NUM_SRC-1:0] maskVec;
  logic [NUM_SRC-1:0] pendingVec;

  prioIrqControl #(
    .NUM_SRC (NUM_SRC),
    .VEC_STEP(VEC_STEP),
    .VEC_W   (VEC_W)
  ) ctrl_i (
    .maskWrEn  (maskWrEn),
    .clrWrEn   (clrWrEn),
    .clrAll    (clrAll),
    .setWrEn   (setWrEn),
    .ack       (ack),
    .globalEn  (globalEn),
    .pendingVec(pendingVec),
    .strobes   (strobes),
    .takeSel   (takeSel),
    .irqReq    (irqReq),
    .irqVec    (irqVec)
  );

  prioIrqDatapath #(
    .NUM_SRC(NUM_SRC)
  ) dp_i (
    .clk       (clk),
    .rstN      (rstN),
    .strobes   (strobes),
    .srcEvt    (srcEvt),
    .maskWrData(maskWrData),
    .clrWrData (clrWrData),
    .setWrData (setWrData),
    .takeSel   (takeSel),
    .rdSel     (rdSel),
    .postedVec (postedVec),
    .maskVec   (maskVec),
    .pendingVec(pendingVec),
    .rdData    (rdData)
  );

endmodule

// File: rtl/prioIrqChecker.sv
module prioIrqChecker #(
  parameter int NUM_SRC  = 11,
  parameter int VEC_STEP = 4,
  parameter int VEC_W    = 16
) (
  input logic               clk,
  input logic               rstN,
  input logic [NUM_SRC-1:0] srcEvt,
  input logic               globalEn,
  input logic               clrWrEn,
  input logic               clrAll,
  input logic               setWrEn,
  input logic [NUM_SRC-1:0] setWrData,
  input logic               ack,
  input logic               irqReq,
  input logic [VEC_W-1:0]   irqVec,
  input logic [NUM_SRC-1:0] postedVec,
  input logic [NUM_SRC-1:0] maskVec
);

  localparam int IDX_W = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1;

  logic [NUM_SRC-1:0] pendChk;
  logic [VEC_W-1:0]   vecIdx;
  logic [NUM_SRC-1:0] belowMask;
  logic               selPend;

  always_comb begin
    pendChk = postedVec & maskVec;
    vecIdx  = irqVec / VEC_W'(VEC_STEP);
    for (int i = 0; i < NUM_SRC; i++) belowMask[i] = (VEC_W'(i) < vecIdx);
    selPend = (vecIdx < VEC_W'(NUM_SRC)) ? pendChk[vecIdx[IDX_W-1:0]] : 1'b0;
  end

  // R1
  evt_posts_chk: assert property (@(posedge clk) disable iff (!rstN)
    (|srcEvt) |=> ((postedVec & $past(srcEvt)) == $past(srcEvt)));

  // R7
  sw_set_posts_chk: assert property (@(posedge clk) disable iff (!rstN)
    setWrEn |=> ((postedVec & $past(setWrData)) == $past(setWrData)));

  // R2
  drop_needs_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    (|($past(postedVec) & ~postedVec)) |-> $past(clrWrEn || clrAll || (ack && irqReq)));

  // R5
  req_qualified_chk: assert property (@(posedge clk) disable iff (!rstN)
    irqReq == (globalEn && (|pendChk)));

  // R6
  vec_is_winner_chk: assert property (@(posedge clk) disable iff (!rstN)
    irqReq |-> (selPend && ((pendChk & belowMask) == '0)
                && ((irqVec % VEC_W'(VEC_STEP)) == '0)));

  // R6
  vec_idle_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    !irqReq |-> (irqVec == '0));

endmodule

bind prioIrqCtrl prioIrqChecker #(
  .NUM_SRC (NUM_SRC),
  .VEC_STEP(VEC_STEP),
  .VEC_W   (VEC_W)
) chk_i (
  .clk      (clk),
  .rstN     (rstN),
  .srcEvt   (srcEvt),
  .globalEn (globalEn),
  .clrWrEn  (clrWrEn),
  .clrAll   (clrAll),
  .setWrEn  (setWrEn),
  .setWrData(setWrData),
  .ack      (ack),
  .irqReq   (irqReq),
  .irqVec   (irqVec),
  .postedVec(postedVec),
  .maskVec  (maskVec)
);

// File: tb/prioIrqCtrl_tb_top.sv
module prioIrqCtrl_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int N          = 11;
  localparam int STEP       = 4;
  localparam int VW         = 16;
  localparam logic [N-1:0] ALL = '1;

  logic          clk = 1'b0;
  logic          rstN;
  logic [N-1:0]  srcEvt;
  logic          globalEn;
  logic          maskWrEn;
  logic [N-1:0]  maskWrData;
  logic          clrWrEn;
  logic [N-1:0]  clrWrData;
  logic          clrAll;
  logic          setWrEn;
  logic [N-1:0]  setWrData;
  logic          ack;
  logic [1:0]    rdSel;
  logic          irqReq;
  logic [VW-1:0] irqVec;
  logic [N-1:0]  rdData;

  int  nChecks = 0;
  int  nFails  = 0;
  bit  done    = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  prioIrqCtrl #(.NUM_SRC(N), .VEC_STEP(STEP), .VEC_W(VW)) dut_i (
    .clk(clk), .rstN(rstN), .srcEvt(srcEvt), .globalEn(globalEn),
    .maskWrEn(maskWrEn), .maskWrData(maskWrData), .clrWrEn(clrWrEn),
    .clrWrData(clrWrData), .clrAll(clrAll), .setWrEn(setWrEn),
    .setWrData(setWrData), .ack(ack), .rdSel(rdSel), .irqReq(irqReq),
    .irqVec(irqVec), .rdData(rdData)
  );

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic idleInputs();
    srcEvt = '0; maskWrEn = 0; maskWrData = '0; clrWrEn = 0; clrWrData = '0;
    clrAll = 0; setWrEn = 0; setWrData = '0; ack = 0;
  endtask

  task automatic readReg(input logic [1:0] sel, output logic [N-1:0] val);
    rdSel = sel;
    #1;
    val = rdData;
  endtask

  function automatic int lowestIdx(input logic [N-1:0] v);
    for (int i = 0; i < N; i++) if (v[i]) return i;
    return -1;
  endfunction

  task automatic writeMask(input logic [N-1:0] m);
    maskWrEn = 1; maskWrData = m; tick(); maskWrEn = 0;
  endtask

  task automatic swSet(input logic [N-1:0] v);
    setWrEn = 1; setWrData = v; tick(); setWrEn = 0; setWrData = '0;
  endtask

  task automatic doClrAll();
    clrAll = 1; tick(); clrAll = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nChecks++; nFails++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
      $finish;
    end
  end

  initial begin
    logic [N-1:0] v, exp;
    int idx;
    idleInputs();
    globalEn = 0; rdSel = 2'd0; rstN = 0;
    @(negedge clk);
    srcEvt = ALL; setWrEn = 1; setWrData = ALL; maskWrEn = 1; maskWrData = ALL;
    repeat (3) tick();
    idleInputs();
    tick();
    rstN = 1;

    // R11 reset state
    readReg(2'd0, v); check(v == '0, "R11 mask after reset", 32'(v), 0);
    readReg(2'd1, v); check(v == '0, "R11 posted after reset", 32'(v), 0);
    check(irqReq == 0, "R11 irqReq after reset", 32'(irqReq), 0);

    // R1, R4, R8: each source posts while masked, then clears singly
    for (int i = 0; i < N; i++) begin
      srcEvt = N'(1) << i; tick(); srcEvt = '0;
      readReg(2'd1, v); check(v == (N'(1) << i), "R1 event posts", 32'(v), 32'(N'(1) << i));
      check(irqReq == 0, "R4 masked source no request", 32'(irqReq), 0);
      clrWrEn = 1; clrWrData = N'(1) << i; tick(); clrWrEn = 0; clrWrData = '0;
      readReg(2'd1, v); check(v == '0, "R8 single clear", 32'(v), 0);
    end

    // R3 read select 3 returns zero
    swSet(ALL); writeMask(ALL);
    readReg(2'd3, v); check(v == '0, "R3 rdSel 3 zero", 32'(v), 0);
    doClrAll();
    readReg(2'd1, v); check(v == '0, "R8 clear all", 32'(v), 0);

    // R4 masking keeps posted, unmask pends at once
    globalEn = 1;
    swSet(N'(1) << 3); #1;
    check(irqReq && irqVec == 12, "R6 vector for source 3", 32'(irqVec), 12);
    writeMask(ALL & ~(N'(1) << 3));
    readReg(2'd1, v); check(v == (N'(1) << 3), "R4 mask clear keeps posted", 32'(v), 8);
    check(irqReq == 0, "R4 masked source drops request", 32'(irqReq), 0);
    srcEvt = N'(1) << 3; tick(); srcEvt = '0;
    readReg(2'd1, v); check(v == (N'(1) << 3), "R4 masked event still posts", 32'(v), 8);
    writeMask(ALL); #1;
    check(irqReq && irqVec == 12, "R4 unmask pends at once", 32'(irqVec), 12);
    doClrAll();

    // R6, R5 exhaustive pattern sweep
    for (int p = 1; p < (1 << N); p++) begin
      swSet(N'(p));
      readReg(2'd2, v); check(v == N'(p), "R3 pending equals posted and mask", 32'(v), 32'(p));
      idx = lowestIdx(N'(p));
      check(irqReq && irqVec == VW'(idx * STEP), "R6 lowest index vector", 32'(irqVec), 32'(idx * STEP));
      globalEn = 0; #1;
      check(!irqReq && irqVec == 0, "R5 global disable", 32'(irqVec), 0);
      globalEn = 1;
      doClrAll();
    end

    // R3 mask sweep over fully posted vector
    swSet(ALL);
    for (int m = 0; m < (1 << N); m++) begin
      writeMask(N'(m));
      readReg(2'd2, v); check(v == N'(m), "R3 pending readback", 32'(v), 32'(m));
      readReg(2'd0, v); check(v == N'(m), "R3 mask readback", 32'(v), 32'(m));
      check(irqReq == (m != 0), "R5 request follows pending", 32'(irqReq), 32'(m != 0));
    end
    readReg(2'd1, v); check(v == ALL, "R4 mask writes keep posted", 32'(v), 32'(ALL));
    doClrAll(); writeMask(ALL);

    // R9 acknowledge walk
    exp = N'(11'b101_0010_0100);
    swSet(exp);
    globalEn = 0;
    ack = 1; tick(); ack = 0;
    readReg(2'd1, v); check(v == exp, "R9 ack without request ignored", 32'(v), 32'(exp));
    globalEn = 1;
    while (exp != '0) begin
      idx = lowestIdx(exp); #1;
      check(irqVec == VW'(idx * STEP), "R9 presented vector", 32'(irqVec), 32'(idx * STEP));
      ack = 1; tick(); ack = 0;
      exp[idx] = 1'b0;
      readReg(2'd1, v); check(v == exp, "R9 ack clears presented only", 32'(v), 32'(exp));
    end

    // R10 collisions
    swSet(N'(1) << 2);
    clrWrEn = 1; clrWrData = N'(1) << 2; setWrEn = 1; setWrData = N'(1) << 2;
    tick(); idleInputs();
    readReg(2'd1, v); check(v == (N'(1) << 2), "R10 set beats clear", 32'(v), 4);
    clrWrEn = 1; clrWrData = N'(1) << 2; srcEvt = N'(1) << 2;
    tick(); idleInputs();
    readReg(2'd1, v); check(v == (N'(1) << 2), "R10 event beats clear", 32'(v), 4);
    ack = 1; srcEvt = N'(1) << 2;
    tick(); idleInputs();
    readReg(2'd1, v); check(v == (N'(1) << 2), "R10 event beats ack", 32'(v), 4);
    clrAll = 1; srcEvt = N'(1) << 7;
    tick(); idleInputs();
    readReg(2'd1, v); check(v == (N'(1) << 7), "R10 event beats clear all", 32'(v), 128);
    doClrAll();

    // R7 multi-bit set and R11 reset of live state
    swSet(N'(11'h455));
    readReg(2'd1, v); check(v == N'(11'h455), "R7 set register", 32'(v), 32'h455);
    rstN = 0; srcEvt = ALL; tick(); idleInputs(); rstN = 1;
    readReg(2'd1, v); check(v == '0, "R11 reset beats events", 32'(v), 0);
    readReg(2'd0, v); check(v == '0, "R11 reset clears mask", 32'(v), 0);

    done = 1;
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end

endmodule